// File: doc/BRIEF.md
# Multi-channel ADC sequencing controller

This block drives an external successive-approximation converter through a programmed range of analog input channels. Software writes one control word that picks a channel group, a channel count and an operating mode, then sets the run bit. The block then issues one convert request per channel and waits for the converter's completion strobe. It files each returned 10-bit value into the result register that belongs to that channel position, and moves to the next channel with no software action.

There are three modes. In one-pass mode every selected channel is converted once; the block then stops itself by clearing the run bit, and it raises a sticky completion flag. In continuous mode the block wraps back to the first channel and keeps going until software stops it, raising the flag after every full pass. In single mode only one channel is converted. An interrupt line is asserted whenever the completion flag is set and interrupts are enabled. Software can stop a conversion at any time. A later start always begins again at the first channel, and the mode and channel settings are sampled only when a run begins.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word (address 0) and all result registers read 0, conv_req is low and irq is low.
- R2: The control word has these fields: run bit at bit 0, interrupt enable at bit 1, completion flag at bit 2, continuous bit at bit 3, pass bit at bit 4, group bit at bit 5, and the count field at bits 7:6. One-pass mode is pass=1 with continuous=0. In that mode the positions 0 up to count are converted in ascending order, and conv_ch carries {group, position}.
- R3: Each channel gets a conv_req pulse exactly one cycle long. After a completion strobe, the request for the next channel follows with no software write.
- R4: The value returned for position p is stored in the result register at address 1+p and reads back zero-extended from 10 bits.
- R5: A result register changes only on a completion strobe that belongs to a running conversion. A strobe that arrives after a stop is ignored.
- R6: When the last selected position completes in one-pass or single mode, the completion flag becomes 1 and the run bit is cleared by hardware.
- R7: irq is high exactly when the completion flag and interrupt enable are both 1. The flag clears only when software writes 0 to bit 2 after having read the control word with the flag at 1. Writing 0 without such a read leaves it set, and writing 1 never sets it.
- R8: When software writes 0 to the run bit, conversion stops and no further requests are issued. Setting the run bit again restarts at the first position.
- R9: In continuous mode (bit 3 = 1) the block wraps from the last position back to position 0. It sets the completion flag after each pass and keeps the run bit at 1.
- R10: In single mode (bit 3 = 0 and bit 4 = 0) only the position given by the count field is converted, once.
- R11: Changes to the group, count or mode bits written during a run apply only from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1..4 results) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| conv_req | output | 1 | One-cycle convert request |
| conv_ch | output | 3 | Channel for the request: {group, position} |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 10 | Conversion value valid with conv_done |
| irq | output | 1 | Completion interrupt |

## Verification
Some properties are checked on every cycle: the convert request is a single-cycle pulse, no request follows a cleared run bit, result registers hold still without a completion strobe, and the flag stays sticky until a control write. The completion of a pass is also checked against the flag and the run bit. Other behaviour shows only in the bench scenarios. These are the channel order for each group, count and mode; the mapping of values to result addresses; the read-before-clear rule for the flag; that a cancelled conversion is discarded and the restart begins at position 0; and that settings written mid-run are deferred to the next start.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // Control word bit positions; software and the bench both rely on them.
  localparam int BIT_RUN   = 0;
  localparam int BIT_IE    = 1;
  localparam int BIT_FLAG  = 2;
  localparam int BIT_CONT  = 3;
  localparam int BIT_PASS  = 4;
  localparam int BIT_GROUP = 5;
  localparam int BIT_CNT   = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic cont;
    logic pass;
    logic group;
  } seq_mode_t;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int POS_W  = 2,
  parameter int CTRL_W = BIT_CNT + POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              hw_flag_set,
  input  logic              hw_run_clr,
  output logic              run,
  output logic              ie,
  output logic              flag,
  output seq_mode_t         mode,
  output logic [POS_W-1:0]  cnt,
  output logic [CTRL_W-1:0] ctrl_word
);
  logic ctrl_wr, ctrl_rd;
  logic run_q, run_n, flag_q, flag_n, armed_q, armed_n;
  logic ie_q;
  seq_mode_t mode_q;
  logic [POS_W-1:0] cnt_q;

  assign ctrl_wr = wr_en && (wr_addr == '0);
  assign ctrl_rd = rd_en && (rd_addr == '0);

  always_comb begin
    run_n = run_q;
    if (hw_run_clr) run_n = 1'b0;
    if (ctrl_wr)    run_n = wr_ctrl[BIT_RUN];

    flag_n = flag_q;
    if (ctrl_wr && !wr_ctrl[BIT_FLAG] && armed_q) flag_n = 1'b0;
    if (hw_flag_set) flag_n = 1'b1;

    armed_n = armed_q;
    if (ctrl_rd && flag_q) armed_n = 1'b1;
    if (!flag_n)           armed_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      run_q   <= run_n;
      flag_q  <= flag_n;
      armed_q <= armed_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mode_q <= '0;
      cnt_q  <= '0;
    end else if (ctrl_wr) begin
      ie_q         <= wr_ctrl[BIT_IE];
      mode_q.cont  <= wr_ctrl[BIT_CONT];
      mode_q.pass  <= wr_ctrl[BIT_PASS];
      mode_q.group <= wr_ctrl[BIT_GROUP];
      cnt_q        <= wr_ctrl[BIT_CNT +: POS_W];
    end
  end

  assign run  = run_q;
  assign ie   = ie_q;
  assign flag = flag_q;
  assign mode = mode_q;
  assign cnt  = cnt_q;

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[BIT_RUN]          = run_q;
    ctrl_word[BIT_IE]           = ie_q;
    ctrl_word[BIT_FLAG]         = flag_q;
    ctrl_word[BIT_CONT]         = mode_q.cont;
    ctrl_word[BIT_PASS]         = mode_q.pass;
    ctrl_word[BIT_GROUP]        = mode_q.group;
    ctrl_word[BIT_CNT +: POS_W] = cnt_q;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int POS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  seq_mode_t        mode,
  input  logic [POS_W-1:0] cnt,
  input  logic             conv_done,
  output logic             conv_req,
  output logic [POS_W:0]   conv_ch,
  output logic             res_we,
  output logic [POS_W-1:0] res_pos,
  output logic             pass_end,
  output logic             hw_run_clr
);
  seq_state_e       state_q, state_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic             cfg_load;
  seq_mode_t        act_mode_q;
  logic [POS_W-1:0] act_cnt_q;
  logic             act_single;
  logic [POS_W-1:0] first_pos;

  assign act_single = !act_mode_q.pass && !act_mode_q.cont;
  assign first_pos  = act_single ? act_cnt_q : '0;

  always_comb begin
    state_n    = state_q;
    pos_n      = pos_q;
    cfg_load   = 1'b0;
    res_we     = 1'b0;
    pass_end   = 1'b0;
    hw_run_clr = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (run) begin
          cfg_load = 1'b1;
          pos_n    = (!mode.pass && !mode.cont) ? cnt : '0;
          state_n  = ST_REQ;
        end
      end
      ST_REQ: begin
        state_n = run ? ST_WAIT : ST_IDLE;
      end
      ST_WAIT: begin
        if (!run) begin
          state_n = ST_IDLE;
        end else if (conv_done) begin
          res_we = 1'b1;
          if (pos_q == act_cnt_q) begin
            pass_end = 1'b1;
            if (act_mode_q.cont) begin
              pos_n   = first_pos;
              state_n = ST_REQ;
            end else begin
              hw_run_clr = 1'b1;
              state_n    = ST_IDLE;
            end
          end else begin
            pos_n   = POS_W'(pos_q + 1'b1);
            state_n = ST_REQ;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
    end else begin
      state_q <= state_n;
      pos_q   <= pos_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode_q <= '0;
      act_cnt_q  <= '0;
    end else if (cfg_load) begin
      act_mode_q <= mode;
      act_cnt_q  <= cnt;
    end
  end

  assign conv_req = (state_q == ST_REQ);
  assign conv_ch  = {act_mode_q.group, pos_q};
  assign res_pos  = pos_q;
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int N_POS = 4,
  parameter int RES_W = 10,
  parameter int POS_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [POS_W-1:0]       pos,
  input  logic [RES_W-1:0]       data,
  output logic [N_POS*RES_W-1:0] res_flat
);
  for (genvar g = 0; g < N_POS; g++) begin : g_slot
    logic slot_en;
    logic [RES_W-1:0] slot_q;
    assign slot_en = we && (pos == POS_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= data;
    end
    assign res_flat[g*RES_W +: RES_W] = slot_q;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_POS  = 4,
  parameter int RES_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 conv_req,
  output logic [$clog2(N_POS):0] conv_ch,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_data,
  output logic                 irq
);
  localparam int POS_W  = $clog2(N_POS);
  localparam int CTRL_W = BIT_CNT + POS_W;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic                   run_q, ie_q, flag_q;
  seq_mode_t              mode_q;
  logic [POS_W-1:0]       cnt_q;
  logic [CTRL_W-1:0]      ctrl_word;
  logic                   res_we, pass_end, hw_run_clr;
  logic [POS_W-1:0]       res_pos;
  logic [N_POS*RES_W-1:0] res_flat;
  logic                   unused_wdata;

  assign unused_wdata = ^wr_data[DATA_W-1:CTRL_W];

  adc_seq_regs #(.ADDR_W(ADDR_W), .POS_W(POS_W), .CTRL_W(CTRL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_ctrl    (wr_data[CTRL_W-1:0]),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .hw_flag_set(pass_end),
    .hw_run_clr (hw_run_clr),
    .run        (run_q),
    .ie         (ie_q),
    .flag       (flag_q),
    .mode       (mode_q),
    .cnt        (cnt_q),
    .ctrl_word  (ctrl_word)
  );

  adc_seq_fsm #(.POS_W(POS_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (run_q),
    .mode      (mode_q),
    .cnt       (cnt_q),
    .conv_done (conv_done),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .res_we    (res_we),
    .res_pos   (res_pos),
    .pass_end  (pass_end),
    .hw_run_clr(hw_run_clr)
  );

  adc_seq_results #(.N_POS(N_POS), .RES_W(RES_W), .POS_W(POS_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (res_we),
    .pos     (res_pos),
    .data    (conv_data),
    .res_flat(res_flat)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = DATA_W'(ctrl_word);
    for (int i = 0; i < N_POS; i++) begin
      if (rd_addr == ADDR_W'(i + 1)) rd_data = DATA_W'(res_flat[i*RES_W +: RES_W]);
    end
  end

  assign irq = flag_q && ie_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int ADDR_W = 3,
  parameter int FLAT_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              conv_req,
  input logic              conv_done,
  input logic              run,
  input logic              flag,
  input logic              irq,
  input logic              pass_end,
  input logic              hw_run_clr,
  input logic [FLAT_W-1:0] res_flat
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == '0);

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  p_stop_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !conv_req);

  p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(res_flat));

  p_pass_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> flag);

  p_hw_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_run_clr && !ctrl_wr) |=> !run);

  p_cont_keeps_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !hw_run_clr && !ctrl_wr) |=> run);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ctrl_wr) |=> flag);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.ADDR_W(ADDR_W), .FLAT_W(N_POS*RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .conv_req  (conv_req),
  .conv_done (conv_done),
  .run       (run_q),
  .flag      (flag_q),
  .irq       (irq),
  .pass_end  (pass_end),
  .hw_run_clr(hw_run_clr),
  .res_flat  (res_flat)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int LAT = 6;
  localparam logic [15:0] RUN = 16'h01, IE = 16'h02, FLG = 16'h04,
                          CONT = 16'h08, PASS = 16'h10, GRP = 16'h20;
  // {single, group, count}
  localparam logic [3:0] VEC [7] = '{4'b0010, 4'b0000, 4'b0111, 4'b0101,
                                     4'b0011, 4'b1110, 4'b1001};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, conv_done = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [9:0] conv_data = '0;
  logic conv_req, irq;
  logic [2:0] conv_ch;

  int tests = 0, fails = 0;
  int req_cnt = 0, nreq = 0, pend = 0;
  logic [2:0] req_log [16];
  logic [2:0] cur_ch;
  logic [9:0] model_val [4];

  always #5 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .conv_req(conv_req),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data), .irq(irq));

  // converter stand-in: fixed latency, delivers even after a stop
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        conv_done = 1'b1;
        conv_data = 10'((cur_ch * 61 + nreq * 37 + 3) % 1024);
        model_val[cur_ch[1:0]] = conv_data;
        nreq = nreq + 1;
      end
    end
    if (conv_req) begin
      pend = LAT;
      cur_ch = conv_ch;
      if (req_cnt < 16) req_log[req_cnt] = conv_ch;
      req_cnt = req_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic wait_req(input int n);
    while (req_cnt < n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [15:0] d, ctrl, pre;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 conv_req", conv_req, 0);
    chk("R1 irq", irq, 0);
    bus_rd(3'd0, d); chk("R1 ctrl", d, 0);
    for (int p = 0; p < 4; p++) begin
      bus_rd(3'(p + 1), d); chk("R1 result", d, 0);
    end

    // table walk: R2 R3 R4 R6 R10
    for (int v = 0; v < 7; v++) begin
      logic sg; logic gp; logic [1:0] ct; int first, n;
      {sg, gp, ct} = VEC[v];
      first = sg ? int'(ct) : 0;
      n = sg ? 1 : int'(ct) + 1;
      ctrl = RUN | IE | (sg ? 16'h0 : PASS) | (gp ? GRP : 16'h0) | (16'(ct) << 6);
      req_cnt = 0;
      bus_wr(3'd0, ctrl);
      wait_irq();
      chk(sg ? "R10 request count" : "R3 request count", req_cnt, n);
      for (int k = 0; k < n; k++)
        chk(sg ? "R10 channel" : "R2 channel order", req_log[k], {gp, 2'(first + k)});
      for (int k = 0; k < n; k++) begin
        bus_rd(3'(first + k + 1), d);
        chk("R4 result slot", d, {6'b0, model_val[first + k]});
      end
      bus_rd(3'd0, d); chk("R6 run cleared, flag set", d, (ctrl & ~RUN) | FLG);
      bus_wr(3'd0, 16'h0);
      bus_rd(3'd0, d); chk("R7 flag cleared after read", d, 0);
      chk("R7 irq low", irq, 0);
    end

    // R9 continuous mode, group 1, count 1
    req_cnt = 0;
    bus_wr(3'd0, RUN | CONT | GRP | 16'h40);
    wait_req(5);
    for (int k = 0; k < 5; k++) chk("R9 wrap order", req_log[k], (k % 2 == 0) ? 3'd4 : 3'd5);
    bus_rd(3'd0, d);
    chk("R9 run stays", d[0], 1);
    chk("R9 flag each pass", d[2], 1);
    bus_wr(3'd0, 16'h0);
    repeat (LAT + 4) @(negedge clk);
    pre = 16'(req_cnt);
    repeat (20) @(negedge clk);
    chk("R8 no request after stop", req_cnt, pre);

    // R8/R5 cancel mid-conversion and restart
    bus_rd(3'd1, pre);
    req_cnt = 0;
    bus_wr(3'd0, RUN | PASS | 16'hC0);
    wait_req(1);
    bus_wr(3'd0, PASS | 16'hC0);
    repeat (20) @(negedge clk);
    chk("R8 single request before stop", req_cnt, 1);
    bus_rd(3'd1, d); chk("R5 cancelled result dropped", d, pre);
    req_cnt = 0;
    bus_wr(3'd0, RUN | IE | PASS | 16'hC0);
    wait_irq();
    chk("R8 restart at first", req_log[0], 0);
    chk("R8 full pass", req_cnt, 4);
    bus_rd(3'd1, d); chk("R5 result after restart", d, {6'b0, model_val[0]});
    bus_rd(3'd0, d);
    bus_wr(3'd0, 16'h0);

    // R11 settings written mid-run are deferred
    req_cnt = 0;
    bus_wr(3'd0, RUN | IE | PASS | 16'hC0);
    wait_req(1);
    bus_wr(3'd0, RUN | IE | PASS | GRP);
    wait_irq();
    chk("R11 old count kept", req_cnt, 4);
    chk("R11 old group kept", req_log[3], 3);
    bus_rd(3'd0, d); chk("R11 new bits stored", d, IE | PASS | GRP | FLG);
    bus_wr(3'd0, IE | PASS | GRP);
    req_cnt = 0;
    bus_wr(3'd0, RUN | IE | PASS | GRP);
    wait_irq();
    chk("R11 new setting at next start", req_cnt, 1);
    chk("R11 new group used", req_log[0], 4);

    // R7 flag clear needs a prior read; writing 1 never sets it
    bus_wr(3'd0, IE | PASS | GRP);
    chk("R7 clear without read ignored", irq, 1);
    bus_rd(3'd0, d);
    bus_wr(3'd0, IE | PASS | GRP);
    chk("R7 clear after read", irq, 0);
    bus_wr(3'd0, IE | FLG);
    chk("R7 writing 1 has no effect", irq, 0);
    bus_rd(3'd0, d); chk("R7 flag still 0", d[2], 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule